// File: doc/BRIEF.md
# Reset-Sampled Operating Mode Controller

This block fixes the device operating mode from three select pins. While reset is held low the pins are sampled on every clock edge; once reset is released the captured code is frozen and any later pin activity is ignored until the next reset. The frozen code is decoded into a set of static control levels for the rest of the chip: the mode class (normal or special), whether an external expansion bus exists, whether that bus carries wide (16-bit) or narrow (8-bit) data, whether the processor comes up under background debug control, and whether the processor is held idle so an outside master can own the bus.

The block also owns a small file of control registers behind a single write port. Each register has a write-once input that marks it as protected. In the special class a protected register can be rewritten freely, which suits factory and test flows. In the normal class it takes the first write after reset and refuses every later one, and each refused write sets a sticky violation flag.

Top module: `opmode_ctrl`

## Requirements
- R1: `mode_code` equals the value on `mode_pins` at the last clock edge with `rst_n` low, and it does not change while `rst_n` stays high, whatever the pins do.
- R2: `special_cls` is 1 for codes 000, 001, 010, 011 and 110, and 0 for the normal codes 100, 101 and 111.
- R3: `ext_bus` is 0 for the two single-chip codes 000 and 100, and 1 for every other code.
- R4: `bus_wide` is 1 for codes 010, 011, 110 and 111, and 0 for the narrow codes 001 and 101 and the single-chip codes.
- R5: `dbg_start` is 1 only for code 000.
- R6: `cpu_hold` is 1 only for code 110.
- R7: A write to a register whose `wr_once` bit is 0 always updates it. The new value is visible on `regs_q` one clock after the strobe. Register i occupies `regs_q[i*DATA_W +: DATA_W]`.
- R8: In the special class a protected register takes every write, and `viol` stays 0.
- R9: In the normal class a protected register takes the first write after reset. Every later write to it leaves it unchanged and sets `viol` one clock after the strobe.
- R10: `viol` stays 1 until reset. Reset clears every register to 0, clears `viol`, and re-arms every write-once register.
- R11: A write to an address of NUM_REGS or more changes no register and does not change `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the pins are sampled while it is low |
| mode_pins | input | 3 | Mode select pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index for the write |
| wr_data | input | DATA_W | Data for the write |
| wr_once | input | NUM_REGS | Per-register protection flag (1 = write-once in normal modes) |
| mode_code | output | 3 | Frozen mode code |
| special_cls | output | 1 | 1 = special class |
| ext_bus | output | 1 | External expansion bus present |
| bus_wide | output | 1 | 1 = 16-bit data, 0 = 8-bit data |
| dbg_start | output | 1 | Processor starts in background debug |
| cpu_hold | output | 1 | Processor held inactive |
| regs_q | output | NUM_REGS*DATA_W | Register file contents |
| viol | output | 1 | Sticky protection violation flag |

## Verification
All eight pin codes are applied through reset, and the pins are inverted right after release. A decoder that followed the live pins instead of the captured ones would then show the wrong outputs. Each code's five decoded levels are compared as a whole, which separates neighbouring codes such as the emulation modes and their normal counterparts. Write sequences are run in a normal mode, the special test mode and an emulation mode: repeated writes to a protected register, writes to an unprotected register, and writes to an unused address. Together they separate first-write acceptance, refusal of later writes, the class-based lifting of protection and violation stickiness.

// File: rtl/opmode_pkg.sv
// Package: shared mode codes and decoded control bundle for the
// operating mode controller. Assumes a 3-bit pin encoding.
package opmode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_SPC_SC   = 3'b000,
        MD_EMU_NAR  = 3'b001,
        MD_SPC_TST  = 3'b010,
        MD_EMU_WIDE = 3'b011,
        MD_NRM_SC   = 3'b100,
        MD_NRM_NAR  = 3'b101,
        MD_SPC_PER  = 3'b110,
        MD_NRM_WIDE = 3'b111
    } opmode_e;

    typedef struct packed {
        logic special;
        logic ext_bus;
        logic bus_wide;
        logic dbg_start;
        logic cpu_hold;
    } mode_ctl_t;

endpackage

// File: rtl/opmode_latch.sv
// Module: captures the mode pins on every clock edge while reset is low,
// then holds the value. Assumes the pins are stable near reset release.
module opmode_latch
    import opmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] pins,
    output opmode_e           mode_q
);

    // Sample during reset, freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= opmode_e'(pins);
        end
    end

endmodule

// File: rtl/opmode_decode.sv
// Module: combinational decode of the frozen mode into chip control levels.
// Emulation modes count as special but copy their normal bus shape.
module opmode_decode
    import opmode_pkg::*;
(
    input  opmode_e   mode,
    output mode_ctl_t ctl
);

    // Map each mode code to its class, bus shape and processor start state.
    always_comb begin
        ctl = '0;
        unique case (mode)
            MD_SPC_SC: begin
                ctl.special   = 1'b1;
                ctl.dbg_start = 1'b1;
            end
            MD_EMU_NAR: begin
                ctl.special = 1'b1;
                ctl.ext_bus = 1'b1;
            end
            MD_SPC_TST: begin
                ctl.special  = 1'b1;
                ctl.ext_bus  = 1'b1;
                ctl.bus_wide = 1'b1;
            end
            MD_EMU_WIDE: begin
                ctl.special  = 1'b1;
                ctl.ext_bus  = 1'b1;
                ctl.bus_wide = 1'b1;
            end
            MD_NRM_SC: begin
                ctl = '0;
            end
            MD_NRM_NAR: begin
                ctl.ext_bus = 1'b1;
            end
            MD_SPC_PER: begin
                ctl.special  = 1'b1;
                ctl.ext_bus  = 1'b1;
                ctl.bus_wide = 1'b1;
                ctl.cpu_hold = 1'b1;
            end
            MD_NRM_WIDE: begin
                ctl.ext_bus  = 1'b1;
                ctl.bus_wide = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/prot_regfile.sv
// Module: small register file with per-register write-once protection.
// Protection applies only while special_cls is low. Refused writes set
// a sticky violation flag. Addresses of NUM_REGS or more are ignored.
module prot_regfile #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       special_cls,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_REGS-1:0]        wr_once,
    output logic [NUM_REGS*DATA_W-1:0] regs_q,
    output logic                       viol
);

    logic [NUM_REGS-1:0] refused;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic              hit;
            logic              locked;
            logic              used_q;
            logic [DATA_W-1:0] data_q;

            assign hit    = wr_en && (wr_addr == ADDR_W'(g));
            assign locked = wr_once[g] && !special_cls && used_q;
            assign refused[g] = hit && locked;
            assign regs_q[g*DATA_W +: DATA_W] = data_q;

            // Store accepted writes and remember the first one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    used_q <= 1'b0;
                end else if (hit && !locked) begin
                    data_q <= wr_data;
                    used_q <= 1'b1;
                end
            end
        end
    endgenerate

    // Sticky violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else if (|refused) begin
            viol <= 1'b1;
        end
    end

endmodule

// File: rtl/opmode_ctrl.sv
// Module: top of the operating mode controller. Latches the mode at reset,
// decodes it, and gates writes to the protected register file by class.
module opmode_ctrl
    import opmode_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode_pins,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_REGS-1:0]        wr_once,
    output logic [2:0]                 mode_code,
    output logic                       special_cls,
    output logic                       ext_bus,
    output logic                       bus_wide,
    output logic                       dbg_start,
    output logic                       cpu_hold,
    output logic [NUM_REGS*DATA_W-1:0] regs_q,
    output logic                       viol
);

    opmode_e   mode;
    mode_ctl_t ctl;

    opmode_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (mode_pins),
        .mode_q (mode)
    );

    opmode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    prot_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .special_cls (ctl.special),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_once     (wr_once),
        .regs_q      (regs_q),
        .viol        (viol)
    );

    // Drive the decoded levels onto the ports.
    always_comb begin
        mode_code   = mode;
        special_cls = ctl.special;
        ext_bus     = ctl.ext_bus;
        bus_wide    = ctl.bus_wide;
        dbg_start   = ctl.dbg_start;
        cpu_hold    = ctl.cpu_hold;
    end

endmodule

// File: rtl/opmode_ctrl_chk.sv
// Checker: temporal properties of the operating mode controller, bound
// to every instance of the top module.
module opmode_ctrl_chk #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [2:0]                 mode_code,
    input logic                       special_cls,
    input logic                       ext_bus,
    input logic                       bus_wide,
    input logic                       dbg_start,
    input logic                       cpu_hold,
    input logic [NUM_REGS*DATA_W-1:0] regs_q,
    input logic                       viol
);

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_code));

    // R2
    normal_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !special_cls |-> mode_code[2]);

    // R4
    wide_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wide |-> ext_bus);

    // R5
    dbg_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_start |-> (!ext_bus && special_cls));

    // R6
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> (ext_bus && special_cls && !dbg_start));

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> ($past(wr_en) && !special_cls));

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(viol)) |-> viol);

    // R11
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_addr) >= ADDR_W'(NUM_REGS)))
        |-> ($stable(regs_q) && $stable(viol)));

endmodule

bind opmode_ctrl opmode_ctrl_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .mode_code   (mode_code),
    .special_cls (special_cls),
    .ext_bus     (ext_bus),
    .bus_wide    (bus_wide),
    .dbg_start   (dbg_start),
    .cpu_hold    (cpu_hold),
    .regs_q      (regs_q),
    .viol        (viol)
);

// File: tb/sim_opmode_ctrl.sv
// Bench: walks all mode codes from a vector table, then runs directed
// write-protection and reset tests.
module sim_opmode_ctrl;

    localparam int NUM_REGS = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int RW       = NUM_REGS * DATA_W;

    // {pins, special, ext_bus, bus_wide, dbg_start, cpu_hold}
    localparam logic [7:0] VEC [8] = '{
        8'b000_10010, 8'b001_11000, 8'b010_11100, 8'b011_11100,
        8'b100_00000, 8'b101_01000, 8'b110_11101, 8'b111_01100
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_pins = 3'b000;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NUM_REGS-1:0] wr_once = 4'b0110;
    logic [2:0]        mode_code;
    logic              special_cls, ext_bus, bus_wide, dbg_start, cpu_hold;
    logic [RW-1:0]     regs_q;
    logic              viol;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [RW-1:0] exp_regs;

    always #2.5 clk = ~clk;

    opmode_ctrl #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_once(wr_once),
        .mode_code(mode_code), .special_cls(special_cls), .ext_bus(ext_bus),
        .bus_wide(bus_wide), .dbg_start(dbg_start), .cpu_hold(cpu_hold),
        .regs_q(regs_q), .viol(viol)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] pins);
        @(negedge clk);
        rst_n = 1'b0;
        mode_pins = pins;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mode_pins = ~pins;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Decode of every mode code; pins are inverted after release (R1).
        for (int i = 0; i < 8; i++) begin
            do_reset(VEC[i][7:5]);
            repeat (2) @(negedge clk);
            chk("R1 mode_code frozen", 64'(mode_code), 64'(VEC[i][7:5]));
            chk("R2 R3 R4 R5 R6 decode",
                64'({special_cls, ext_bus, bus_wide, dbg_start, cpu_hold}),
                64'(VEC[i][4:0]));
        end

        // Normal single-chip mode, regs 1 and 2 protected.
        do_reset(3'b100);
        chk("R10 reset regs", 64'(regs_q), 64'(0));
        chk("R10 reset viol", 64'(viol), 64'(0));
        do_write(3'd1, 8'hA5);
        exp_regs = '0;
        exp_regs[15:8] = 8'hA5;
        chk("R9 first write taken", 64'(regs_q), 64'(exp_regs));
        chk("R9 no viol on first", 64'(viol), 64'(0));
        do_write(3'd1, 8'h3C);
        chk("R9 second write ignored", 64'(regs_q), 64'(exp_regs));
        chk("R9 viol set", 64'(viol), 64'(1));
        do_write(3'd0, 8'h11);
        do_write(3'd0, 8'h22);
        exp_regs[7:0] = 8'h22;
        chk("R7 unprotected rewrite", 64'(regs_q), 64'(exp_regs));
        repeat (3) @(negedge clk);
        chk("R10 viol sticky", 64'(viol), 64'(1));
        do_write(3'd5, 8'hFF);
        do_write(3'd4, 8'hEE);
        chk("R11 bad address ignored", 64'(regs_q), 64'(exp_regs));

        // Out-of-range write must not raise viol (R11).
        do_reset(3'b111);
        do_write(3'd6, 8'h5A);
        chk("R11 bad address no viol", 64'(viol), 64'(0));
        chk("R11 bad address regs", 64'(regs_q), 64'(0));
        do_write(3'd2, 8'h77);
        do_write(3'd2, 8'h88);
        exp_regs = '0;
        exp_regs[23:16] = 8'h77;
        chk("R9 normal wide lock", 64'(regs_q), 64'(exp_regs));
        chk("R9 normal wide viol", 64'(viol), 64'(1));

        // Special test mode: protection lifted (R8); reset clears (R10).
        do_reset(3'b010);
        chk("R10 reset clears viol", 64'(viol), 64'(0));
        chk("R10 reset clears regs", 64'(regs_q), 64'(0));
        do_write(3'd2, 8'h01);
        do_write(3'd2, 8'h02);
        do_write(3'd2, 8'h03);
        exp_regs = '0;
        exp_regs[23:16] = 8'h03;
        chk("R8 test mode rewrite", 64'(regs_q), 64'(exp_regs));
        chk("R8 test mode no viol", 64'(viol), 64'(0));

        // Emulation wide counts as special (R8).
        do_reset(3'b011);
        do_write(3'd1, 8'h10);
        do_write(3'd1, 8'h20);
        exp_regs = '0;
        exp_regs[15:8] = 8'h20;
        chk("R8 emulation rewrite", 64'(regs_q), 64'(exp_regs));
        chk("R8 emulation no viol", 64'(viol), 64'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule